// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control section of a small accumulator processor. Each cycle it forms a 12-bit control-store address from three fields. The upper eight bits are the opcode held in the instruction register. The next bit is a condition bit. The low three bits are a micro-step counter. The block looks up a 32-bit microword in a constant table held inside it and registers that word before it drives the datapath. A few bits of the registered word are also brought out as the memory and I/O read and write strobes.

Every instruction owns a 16-word region of the store. The condition bit takes the value of the zero flag only while the microword selected with that bit at 0 has its conditional-enable bit (bit 27) set. In that case the region splits into a half for "flag clear" and a half for "flag set", and the same opcode can run two different sequences. The micro-step counter advances once per cycle and returns to 0 after any microword whose end bit (bit 31) is set.

The built-in microprogram has two routines:
- the fetch routine, opcode 00h, which runs first after reset because the instruction register then holds 00h;
- a jump-if-not-zero routine, opcode 28h.

External reset passes through a synchronizing flip-flop before it reaches the counter and the output register.

Top module: `mcode_seq`

## Requirements
- R1: While the synchronized reset is active, `ctrl_bits` is all zero and all four strobes are low.
- R2: Reset enters and leaves through one synchronizing stage. After `rst_n` changes at a falling clock edge, the next rising edge still acts with the old reset state. The following rising edge is the first to act with the new state.
- R3: With opcode 00h the outputs step through three words on consecutive cycles: 0x000000E2, then 0x00000522, then 0x80001800. The first word follows on the second rising edge after reset is released.
- R4: After a word with bit 31 set is presented, the next word is step 0 of the opcode then present. Otherwise the step advances by one each cycle.
- R5: Address layout is opcode in bits 11..4, condition in bit 3, step in bits 2..0. Bit 3 equals `zero_flag` only when bit 27 of the word at the same opcode and step with bit 3 cleared is set; otherwise it is 0. So the fetch words do not depend on `zero_flag`.
- R6: Opcode 28h with `zero_flag`=0 gives 0x080000E2, then 0x08000422, then 0x88000A01. The last word loads the instruction pointer and clears the instruction register (bit 0).
- R7: Opcode 28h with `zero_flag`=1 at step 0 gives the single word 0x88000101: condition enable, pointer increment (bit 8), instruction-register clear (bit 0) and end.
- R8: Any address without a programmed word yields 0x80000000, with only the end bit set. Bit 29 of `ctrl_bits` is never set.
- R9: `ctrl_bits` is registered. It shows the word addressed at the previous rising edge. A change of `ir_code` or `zero_flag` between edges does not move it.
- R10: `mem_rd`, `mem_wr`, `io_rd` and `io_wr` are `ctrl_bits` bits 1, 2, 3 and 4. At most one of them is high in any cycle.
- R11: Reset asserted in the middle of an instruction stops the sequence, and after release execution restarts at step 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, unsynchronized |
| ir_code | input | 8 | Opcode from the instruction register |
| zero_flag | input | 1 | Zero condition flag |
| ctrl_bits | output | 32 | Registered microword driving the datapath |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
Two functions can fall in the same cycle: choosing the flag-set half of a region and reloading the step counter to 0. This happens when the condition selects a word that also carries the end bit. The bench provokes it in two ways. First, it presents opcode 28h with the flag set at step 0. Second, it raises the flag after the first jump step, so that step 1 lands on an unprogrammed word in the flag-set half. In both cases the word that appears is checked, and the following cycle must show step 0 of whatever opcode is present. A third collision is reset arriving mid-sequence while the counter advances. It is judged by the one word that still slips through the synchronizer, the zero words after it, and a clean restart at step 0.

// File: rtl/mcs_pkg.sv
// Shared constants for the microprogrammed sequencer: field widths,
// control-bit positions and the opcodes covered by the built-in microprogram.
package mcs_pkg;
    localparam int OP_W   = 8;
    localparam int UPC_W  = 3;
    localparam int CW_W   = 32;
    localparam int CS_AW  = OP_W + 1 + UPC_W;

    localparam int CB_IR_CLR  = 0;
    localparam int CB_MEM_RD  = 1;
    localparam int CB_MEM_WR  = 2;
    localparam int CB_IO_RD   = 3;
    localparam int CB_IO_WR   = 4;
    localparam int CB_ADDR_OE = 5;
    localparam int CB_AR_LD   = 6;
    localparam int CB_IP_OE   = 7;
    localparam int CB_IP_INC  = 8;
    localparam int CB_IP_LD   = 9;
    localparam int CB_DR_LD   = 10;
    localparam int CB_DR_OE   = 11;
    localparam int CB_IR_LD   = 12;
    localparam int CB_COND_EN = 27;
    localparam int CB_SPARE   = 29;
    localparam int CB_LAST    = 31;

    localparam logic [OP_W-1:0] OPC_FETCH = 8'h00;
    localparam logic [OP_W-1:0] OPC_JNZ   = 8'h28;

    typedef logic [CW_W-1:0] cword_t;
endpackage

// File: rtl/mcs_rst_sync.sv
// Reset synchronizer: a chain of STAGES flops carrying the active-low reset.
// Assumes rst_n is held long enough to be seen by the chain.
module mcs_rst_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single stage: sample the raw reset once.
            always_ff @(posedge clk) chain <= rst_n;
        end else begin : g_many
            // Multi stage: shift the raw reset through the chain.
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], rst_n};
        end
    endgenerate

    assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/mcs_upc.sv
// Micro-step counter: counts one per cycle and reloads 0 on an end word.
// Assumes no routine needs more than 2**UPC_W words.
module mcs_upc
    import mcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_i,
    output logic [UPC_W-1:0] step_o
);
    // Advance the step, or restart on reset or end of routine.
    always_ff @(posedge clk) begin
        if (!rst_n)      step_o <= '0;
        else if (last_i) step_o <= '0;
        else             step_o <= step_o + UPC_W'(1);
    end
endmodule

// File: rtl/mcs_store.sv
// Control store: forms the address from opcode, gated flag and step, and
// returns the microword. The conditional enable is read from the word with
// the condition bit at 0, so the address has no combinational loop.
// Unprogrammed addresses return a word holding only the end bit.
module mcs_store
    import mcs_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic             zf_i,
    input  logic [UPC_W-1:0] step_i,
    output logic [CS_AW-1:0] addr_o,
    output cword_t           word_o
);
    function automatic cword_t cb(input int n);
        cword_t r;
        r    = '0;
        r[n] = 1'b1;
        return r;
    endfunction

    function automatic cword_t mc_word(input logic [OP_W-1:0] op,
                                       input logic cond,
                                       input logic [UPC_W-1:0] step);
        cword_t w;
        w = cb(CB_LAST);
        if (op == OPC_FETCH && !cond) begin
            case (step)
                UPC_W'(0): w = cb(CB_IP_OE) | cb(CB_AR_LD) | cb(CB_ADDR_OE) | cb(CB_MEM_RD);
                UPC_W'(1): w = cb(CB_DR_LD) | cb(CB_ADDR_OE) | cb(CB_MEM_RD) | cb(CB_IP_INC);
                UPC_W'(2): w = cb(CB_DR_OE) | cb(CB_IR_LD) | cb(CB_LAST);
                default:   w = cb(CB_LAST);
            endcase
        end else if (op == OPC_JNZ && !cond) begin
            case (step)
                UPC_W'(0): w = cb(CB_COND_EN) | cb(CB_IP_OE) | cb(CB_AR_LD)
                             | cb(CB_ADDR_OE) | cb(CB_MEM_RD);
                UPC_W'(1): w = cb(CB_COND_EN) | cb(CB_DR_LD) | cb(CB_ADDR_OE) | cb(CB_MEM_RD);
                UPC_W'(2): w = cb(CB_COND_EN) | cb(CB_DR_OE) | cb(CB_IP_LD)
                             | cb(CB_IR_CLR) | cb(CB_LAST);
                default:   w = cb(CB_LAST);
            endcase
        end else if (op == OPC_JNZ && cond) begin
            if (step == UPC_W'(0))
                w = cb(CB_COND_EN) | cb(CB_IP_INC) | cb(CB_IR_CLR) | cb(CB_LAST);
        end
        return w;
    endfunction

    cword_t word_plain;
    cword_t word_cond;
    logic   sel;

    // Look up both halves and pick one by the gated flag.
    always_comb begin
        word_plain = mc_word(op_i, 1'b0, step_i);
        word_cond  = mc_word(op_i, 1'b1, step_i);
        sel        = word_plain[CB_COND_EN] & zf_i;
        addr_o     = {op_i, sel, step_i};
        word_o     = sel ? word_cond : word_plain;
    end
endmodule

// File: rtl/mcs_pipe.sv
// Output pipeline register: holds the microword for one cycle so that every
// control bit reaches the datapath on the same edge.
module mcs_pipe
    import mcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cword_t d_i,
    output cword_t q_o
);
    // Capture the store output, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/mcode_seq.sv
// Top of the microprogrammed control sequencer: reset synchronizer,
// micro-step counter, control store and output register. Assumes a single
// clock; the counter moves on one edge and its word is registered on the next.
module mcode_seq
    import mcs_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] ir_code,
    input  logic            zero_flag,
    output logic [CW_W-1:0] ctrl_bits,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            io_rd,
    output logic            io_wr
);
    logic             rst_int_n;
    logic [UPC_W-1:0] upc;
    logic [CS_AW-1:0] cs_addr;
    cword_t           cs_word;
    cword_t           ctrl_q;

    mcs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

    mcs_upc u_upc (
        .clk(clk), .rst_n(rst_int_n), .last_i(cs_word[CB_LAST]), .step_o(upc));

    mcs_store u_store (
        .op_i(ir_code), .zf_i(zero_flag), .step_i(upc),
        .addr_o(cs_addr), .word_o(cs_word));

    mcs_pipe u_pipe (
        .clk(clk), .rst_n(rst_int_n), .d_i(cs_word), .q_o(ctrl_q));

    assign ctrl_bits = ctrl_q;
    assign mem_rd    = ctrl_q[CB_MEM_RD];
    assign mem_wr    = ctrl_q[CB_MEM_WR];
    assign io_rd     = ctrl_q[CB_IO_RD];
    assign io_wr     = ctrl_q[CB_IO_WR];
endmodule

// File: rtl/mcode_seq_chk.sv
// Checker for mcode_seq, bound into every instance. Watches the counter,
// store address, store word and registered outputs after synchronized reset.
module mcode_seq_chk
    import mcs_pkg::*;
(
    input logic             clk,
    input logic             sync_n,
    input logic [OP_W-1:0]  ir_code,
    input logic             zero_flag,
    input logic [UPC_W-1:0] upc,
    input logic [CS_AW-1:0] cs_addr,
    input cword_t           cs_word,
    input logic [CW_W-1:0]  ctrl_bits,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             io_rd,
    input logic             io_wr
);
    a_r4_restart: assert property (@(posedge clk) disable iff (!sync_n)
        cs_word[CB_LAST] |=> upc == '0);

    a_r4_advance: assert property (@(posedge clk) disable iff (!sync_n)
        !cs_word[CB_LAST] |=> upc == $past(upc) + UPC_W'(1));

    a_r5_layout: assert property (@(posedge clk) disable iff (!sync_n)
        cs_addr[CS_AW-1:UPC_W+1] == ir_code && cs_addr[UPC_W-1:0] == upc);

    a_r5_gate: assert property (@(posedge clk) disable iff (!sync_n)
        cs_addr[UPC_W] |-> zero_flag);

    a_r5_fetch_plain: assert property (@(posedge clk) disable iff (!sync_n)
        ir_code == OPC_FETCH |-> !cs_addr[UPC_W]);

    a_r8_spare: assert property (@(posedge clk) disable iff (!sync_n)
        !ctrl_bits[CB_SPARE]);

    a_r9_pipe: assert property (@(posedge clk) disable iff (!sync_n)
        sync_n |=> ctrl_bits == $past(cs_word));

    a_r10_strobes: assert property (@(posedge clk) disable iff (!sync_n)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr}));
endmodule

bind mcode_seq mcode_seq_chk u_chk (
    .clk(clk), .sync_n(rst_int_n), .ir_code(ir_code), .zero_flag(zero_flag),
    .upc(upc), .cs_addr(cs_addr), .cs_word(cs_word), .ctrl_bits(ctrl_bits),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr));

// File: tb/mcode_seq_tb.sv
`timescale 1ns/1ps
// Directed bench for mcode_seq: one task per scenario, sampling at the falling edge.
module mcode_seq_tb;
    localparam logic [31:0] W_F0    = 32'h0000_00E2;
    localparam logic [31:0] W_F1    = 32'h0000_0522;
    localparam logic [31:0] W_F2    = 32'h8000_1800;
    localparam logic [31:0] W_J0    = 32'h0800_00E2;
    localparam logic [31:0] W_J1    = 32'h0800_0422;
    localparam logic [31:0] W_J2    = 32'h8800_0A01;
    localparam logic [31:0] W_SKIP  = 32'h8800_0101;
    localparam logic [31:0] W_BLANK = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ir_code = 8'h00;
    logic        zero_flag = 1'b0;
    logic [31:0] ctrl_bits;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    mcode_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ir_code(ir_code), .zero_flag(zero_flag),
        .ctrl_bits(ctrl_bits), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr));

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Check the word and the four strobes (R10: strobes are bits 1..4).
    task automatic expect_word(input string req, input logic [31:0] exp);
        logic [3:0] got_s;
        logic [3:0] exp_s;
        got_s = {io_wr, io_rd, mem_wr, mem_rd};
        exp_s = exp[4:1];
        total++;
        if (ctrl_bits !== exp) begin
            bad++;
            $display("FAIL %s ctrl_bits actual=%h expected=%h", req, ctrl_bits, exp);
        end
        total++;
        if (got_s !== exp_s) begin
            bad++;
            $display("FAIL R10 (%s) strobes actual=%b expected=%b", req, got_s, exp_s);
        end
    endtask

    // R1 R2 R3 R4: reset, one-cycle sync delay, first fetch, then restart.
    task automatic t_reset_fetch();
        rst_n = 1'b0; ir_code = 8'h00; zero_flag = 1'b0;
        repeat (3) tick();
        expect_word("R1", 32'h0);
        rst_n = 1'b1;
        tick();
        expect_word("R2", 32'h0);
        tick(); expect_word("R3", W_F0);
        tick(); expect_word("R3", W_F1);
        tick(); expect_word("R3", W_F2);
        tick(); expect_word("R4", W_F0);
        tick(); expect_word("R4", W_F1);
        tick(); expect_word("R4", W_F2);
    endtask

    // R5: fetch words do not depend on the zero flag.
    task automatic t_fetch_flag();
        zero_flag = 1'b1; ir_code = 8'h00;
        tick(); expect_word("R5", W_F0);
        tick(); expect_word("R5", W_F1);
        tick(); expect_word("R5", W_F2);
    endtask

    // R6: jump with flag clear runs three words.
    task automatic t_jnz_taken();
        zero_flag = 1'b0; ir_code = 8'h28;
        tick(); expect_word("R6", W_J0);
        tick(); expect_word("R6", W_J1);
        tick(); expect_word("R6", W_J2);
    endtask

    // R7: jump with flag set is one word; R4 restart follows with fetch.
    task automatic t_jnz_skip();
        zero_flag = 1'b1; ir_code = 8'h28;
        tick(); expect_word("R7", W_SKIP);
        ir_code = 8'h00;
        tick(); expect_word("R4", W_F0);
        tick(); expect_word("R4", W_F1);
        tick(); expect_word("R4", W_F2);
    endtask

    // R5 R8: flag rises mid-jump, step 1 lands on a blank word in the set half.
    task automatic t_flag_flip();
        zero_flag = 1'b0; ir_code = 8'h28;
        tick(); expect_word("R6", W_J0);
        zero_flag = 1'b1;
        tick(); expect_word("R8", W_BLANK);
        tick(); expect_word("R7", W_SKIP);
    endtask

    // R8: unprogrammed opcodes give only the end bit, repeatedly.
    task automatic t_blank();
        zero_flag = 1'b0; ir_code = 8'h5A;
        tick(); expect_word("R8", W_BLANK);
        tick(); expect_word("R8", W_BLANK);
        zero_flag = 1'b1; ir_code = 8'hFF;
        tick(); expect_word("R8", W_BLANK);
    endtask

    // R9: inputs changing between edges do not move the registered word.
    task automatic t_hold();
        zero_flag = 1'b0; ir_code = 8'h00;
        tick(); expect_word("R9", W_F0);
        ir_code = 8'h28; zero_flag = 1'b1;
        #1;
        expect_word("R9", W_F0);
        tick(); expect_word("R8", W_BLANK);
    endtask

    // R11 R2 R1: reset mid-fetch; one more word slips through, then zeros, then restart.
    task automatic t_reset_mid();
        zero_flag = 1'b0; ir_code = 8'h00;
        tick(); expect_word("R11", W_F0);
        rst_n = 1'b0;
        tick(); expect_word("R2", W_F1);
        tick(); expect_word("R1", 32'h0);
        tick(); expect_word("R1", 32'h0);
        rst_n = 1'b1;
        tick(); expect_word("R2", 32'h0);
        tick(); expect_word("R11", W_F0);
        tick(); expect_word("R11", W_F1);
        tick(); expect_word("R11", W_F2);
    endtask

    initial begin
        @(negedge clk);
        t_reset_fetch();
        t_fetch_flag();
        t_jnz_taken();
        t_jnz_skip();
        t_flag_flip();
        t_blank();
        t_hold();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule